// File: doc/BRIEF.md
# Gated IF Counter

The block measures the frequency of one of two external intermediate-frequency inputs. Software picks the source and a gate length, then issues a start command. While the gate stays open, the block counts rising edges of the selected input into a saturating binary counter. When the gate closes, counting stops and an interrupt flag is raised. Software then reads the result as two bytes and converts the count to a frequency.

The FM-side input passes through a divide-by-2 prescaler before it reaches the counter. The AM-side input is counted directly. The selected input goes through a two-flop synchronizer and a rising-edge detector. The highest rate that can be counted is therefore below half the system clock.

The gate windows come from the system clock frequency, which is a parameter. The control register and the two count bytes share a small byte-wide register port. Reads on that port are combinational.

Top module: `ifc_gated_counter`

## Requirements
- R1: After reset, all four addresses read 0x00 and `irq` is low. Register 0 therefore reads FM source, 1 ms gate, idle, no flag and no overflow.
- R2: Register 0 bit 0 selects the source: 1 for the AM input, 0 for the FM input. The AM input adds one count per rising edge. The FM input adds one count on the 1st, 3rd, 5th and later odd-numbered rising edges after a start.
- R3: Register 0 bits [2:1] set the gate length: 00 = 1 ms, 01 = 4 ms, 10 = 8 ms, and 11 = 8 ms. In system clock cycles the gate stays open for exactly ms × CLK_HZ / 1000 cycles.
- R4: Writing 1 to register 0 bit 3 while the gate is closed does four things in one edge: it clears the count, clears the overflow bit and clears the prescaler, and it opens the gate. Bit 3 reads 1 exactly while the gate is open.
- R5: The count changes only while the gate is open, apart from the clear at a start. After the gate closes, the count holds its value.
- R6: Register 0 bit 4 is the interrupt flag, and `irq` follows it. The flag is set on the edge that closes the gate. It stays set until a write to register 0 with bit 4 = 1. A write with bit 4 = 0 leaves it unchanged.
- R7: The count saturates at all ones (2^CNT_W − 1) and does not wrap. Register 0 bit 5 then reads 1 and stays 1 until the next start.
- R8: Reads are selected by `addr`:
  - address 1 returns count bits [7:0];
  - address 2 returns count bits [15:8], with bits at or above CNT_W reading 0;
  - address 0 returns the control and status byte;
  - address 3 returns 0x00.
- R9: While the gate is open, a write to register 0 has no effect on the start bit, source select or gate length. The running gate keeps its length and the fields keep their values.
- R10: Only rising edges count, and each edge is counted once however long the input stays high. If the input rises just before clock edge k, the count changes after edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fm_in | input | 1 | FM-side IF input, asynchronous, divided by 2 |
| am_in | input | 1 | AM-side IF input, asynchronous, counted directly |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 2 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the register at `addr` (combinational) |
| irq | output | 1 | Gate-closed interrupt flag |

## Verification
The bench builds the block with CLK_HZ = 200000 and CNT_W = 9. These values shrink the three gate windows to 200, 800 and 1600 cycles, so every gate code, including the reserved one, can be timed exactly in a short run. With a 9-bit counter, an AM input toggling every clock cycle passes the saturation point inside an 8 ms window. That brings the no-wrap rule and the overflow bit within reach. It also still exercises the high-byte read path, which holds a single live bit.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

  typedef enum logic [1:0] {
    GATE_1MS = 2'b00,
    GATE_4MS = 2'b01,
    GATE_8MS = 2'b10,
    GATE_RSV = 2'b11
  } gate_code_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_CNT_L = 2'd1;
  localparam logic [1:0] ADDR_CNT_H = 2'd2;

  localparam int CTRL_SRC   = 0;
  localparam int CTRL_GATE0 = 1;
  localparam int CTRL_START = 3;
  localparam int CTRL_IRQ   = 4;
  localparam int CTRL_OVF   = 5;

  localparam int BYTE_W = 8;
  localparam int READ_W = 2 * BYTE_W;

  // Gate length in milliseconds for each code; reserved code maps to the longest window.
  function automatic int unsigned gate_ms(gate_code_e code);
    case (code)
      GATE_1MS: return 1;
      GATE_4MS: return 4;
      default:  return 8;
    endcase
  endfunction

endpackage

// File: rtl/ifc_input_front.sv
module ifc_input_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fm_in,
  input  logic am_in,
  input  logic sel_am,
  input  logic gate_open,
  input  logic clear,
  output logic cnt_pulse
);

  logic                   pin_sel;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   div_q;
  logic                   div_d;
  logic                   rise;
  logic                   sync_out;

  assign pin_sel  = sel_am ? am_in : fm_in;
  assign sync_out = sync_q[SYNC_STAGES-1];

  // Synchronizer chain: stage 0 samples the selected pin, later stages shift.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= pin_sel;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_out;
  end

  assign rise = sync_out & ~prev_q;

  // Divide-by-2 prescaler, only advanced by FM edges inside the gate.
  always_comb begin
    div_d = div_q;
    if (clear)
      div_d = 1'b0;
    else if (gate_open && rise && !sel_am)
      div_d = ~div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        div_q <= 1'b0;
    else if (clear || (gate_open && rise)) div_q <= div_d;
  end

  assign cnt_pulse = gate_open & rise & (sel_am | ~div_q);

endmodule

// File: rtl/ifc_gate_timer.sv
module ifc_gate_timer
  import ifc_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  gate_code_e gate_code,
  output logic       gate_open,
  output logic       close_pulse
);

  localparam int unsigned TICKS_MS  = CLK_HZ / 1000;
  localparam int unsigned MAX_TICKS = 8 * TICKS_MS;
  localparam int          TW        = $clog2(MAX_TICKS + 1);

  logic [TW-1:0] rem_q, rem_d;
  logic          open_q, open_d;
  logic          tick_en;
  logic [TW-1:0] load_val;

  assign load_val    = TW'(gate_ms(gate_code) * TICKS_MS - 1);
  assign close_pulse = open_q && (rem_q == '0);
  assign tick_en     = open_q || start;

  always_comb begin
    open_d = open_q;
    rem_d  = rem_q;
    if (open_q) begin
      if (rem_q == '0) open_d = 1'b0;
      else             rem_d  = rem_q - 1'b1;
    end else if (start) begin
      open_d = 1'b1;
      rem_d  = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rem_q  <= '0;
    end else if (tick_en) begin
      open_q <= open_d;
      rem_q  <= rem_d;
    end
  end

  assign gate_open = open_q;

endmodule

// File: rtl/ifc_sat_counter.sv
module ifc_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             at_max;
  logic             upd_en;

  assign at_max = (cnt_q == CNT_MAX);
  assign upd_en = clear || inc;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (clear) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (inc) begin
      if (at_max) ovf_d = 1'b1;
      else        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign count = cnt_q;
  assign ovf   = ovf_q;

endmodule

// File: rtl/ifc_gated_counter.sv
module ifc_gated_counter
  import ifc_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int          CNT_W  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fm_in,
  input  logic       am_in,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  logic             gate_open;
  logic             close_pulse;
  logic             cnt_pulse;
  logic [CNT_W-1:0] count;
  logic             ovf;

  logic             ctrl_wr, mode_wr, start_acc, w1c;
  logic             src_q, src_d;
  gate_code_e       gate_q, gate_d;
  logic             irq_q, irq_d;
  logic [READ_W-1:0] cnt_ext;

  assign ctrl_wr   = wr_en && (addr == ADDR_CTRL);
  assign mode_wr   = ctrl_wr && !gate_open;
  assign start_acc = mode_wr && wdata[CTRL_START];
  assign w1c       = ctrl_wr && wdata[CTRL_IRQ];

  always_comb begin
    src_d  = src_q;
    gate_d = gate_q;
    if (mode_wr) begin
      src_d  = wdata[CTRL_SRC];
      gate_d = gate_code_e'(wdata[CTRL_GATE0 +: 2]);
    end
  end

  always_comb begin
    irq_d = irq_q;
    if (w1c)         irq_d = 1'b0;
    if (close_pulse) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      src_q  <= 1'b0;
      gate_q <= GATE_1MS;
    end else if (mode_wr) begin
      src_q  <= src_d;
      gate_q <= gate_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)              irq_q <= 1'b0;
    else if (w1c || close_pulse) irq_q <= irq_d;
  end

  ifc_input_front #(.SYNC_STAGES(2)) u_front (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .fm_in     (fm_in),
    .am_in     (am_in),
    .sel_am    (src_q),
    .gate_open (gate_open),
    .clear     (start_acc),
    .cnt_pulse (cnt_pulse)
  );

  ifc_gate_timer #(.CLK_HZ(CLK_HZ)) u_timer (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (start_acc),
    .gate_code   (gate_code_e'(wdata[CTRL_GATE0 +: 2])),
    .gate_open   (gate_open),
    .close_pulse (close_pulse)
  );

  ifc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clear (start_acc),
    .inc   (cnt_pulse),
    .count (count),
    .ovf   (ovf)
  );

  assign cnt_ext = READ_W'(count);

  always_comb begin
    case (addr)
      ADDR_CTRL:  rdata = {2'b00, ovf, irq_q, gate_open, gate_q, src_q};
      ADDR_CNT_L: rdata = cnt_ext[BYTE_W-1:0];
      ADDR_CNT_H: rdata = cnt_ext[READ_W-1:BYTE_W];
      default:    rdata = 8'h00;
    endcase
  end

  assign irq = irq_q;

endmodule

// File: rtl/ifc_gated_counter_chk.sv
module ifc_gated_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             start_acc,
  input logic             gate_open,
  input logic             close_pulse,
  input logic [CNT_W-1:0] count,
  input logic             ovf,
  input logic             irq_flag,
  input logic             w1c
);

  // R4
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    start_acc |=> (count == '0) && gate_open && !ovf);

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!gate_open && !start_acc) |=> $stable(count));

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !start_acc |=> count >= $past(count));

  // R7
  ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ovf |-> (count == '1));

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_flag && !w1c) |=> irq_flag);

  // R6
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    close_pulse |=> irq_flag);

  // R9
  gate_keep_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (gate_open && !close_pulse) |=> gate_open);

  // R3
  gate_close_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    close_pulse |=> !gate_open);

endmodule

bind ifc_gated_counter ifc_gated_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_ni      (rst_int_n),
  .start_acc   (start_acc),
  .gate_open   (gate_open),
  .close_pulse (close_pulse),
  .count       (count),
  .ovf         (ovf),
  .irq_flag    (irq_q),
  .w1c         (w1c)
);

// File: tb/ifc_gated_counter_test.sv
module ifc_gated_counter_test;

  localparam int unsigned CLK_HZ = 200_000;
  localparam int          CNT_W  = 9;
  localparam int          TPM    = CLK_HZ / 1000;
  localparam int          CMAX   = (1 << CNT_W) - 1;

  logic       clk;
  logic       rst_n;
  logic       fm_in, am_in;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;

  int checks, failures;
  bit settled, done;
  int am_half, fm_half, am_ctr, fm_ctr;
  int busy_cycles;

  ifc_gated_counter #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .fm_in(fm_in), .am_in(am_in),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- reference model ----------------
  int m_src, m_gate, m_busy, m_rem, m_cnt, m_ovf, m_irq, m_div;
  bit hist[$];

  function automatic int ms_of(int code);
    return (code == 0) ? 1 : (code == 1) ? 4 : 8;
  endfunction

  function automatic logic [7:0] model_read(logic [1:0] a);
    case (a)
      2'd0: return 8'((m_ovf << 5) | (m_irq << 4) | (m_busy << 3) | (m_gate << 1) | m_src);
      2'd1: return 8'(m_cnt & 255);
      2'd2: return 8'(m_cnt >> 8);
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_src = 0; m_gate = 0; m_busy = 0; m_rem = 0;
      m_cnt = 0; m_ovf = 0; m_irq = 0; m_div = 0;
      hist = '{0, 0, 0};
    end else begin
      int  ob, cls;
      bit  pin, rise;
      ob  = m_busy;
      cls = 0;
      pin = (m_src != 0) ? am_in : fm_in;
      rise = hist[1] && !hist[2];
      hist.push_front(pin);
      void'(hist.pop_back());
      if (m_busy != 0) begin
        if (rise) begin
          if (m_src != 0 || m_div == 0) begin
            if (m_cnt == CMAX) m_ovf = 1; else m_cnt++;
          end
          if (m_src == 0) m_div = 1 - m_div;
        end
        if (m_rem == 0) begin m_busy = 0; cls = 1; end
        else m_rem--;
      end
      if (wr_en && addr == 2'd0) begin
        if (wdata[4]) m_irq = 0;
        if (ob == 0) begin
          m_src  = wdata[0];
          m_gate = wdata[2:1];
          if (wdata[3]) begin
            m_cnt = 0; m_ovf = 0; m_div = 0; m_busy = 1;
            m_rem = ms_of(wdata[2:1]) * TPM - 1;
          end
        end
      end
      if (cls != 0) m_irq = 1;
    end
  end

  // ---------------- checking ----------------
  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always @(posedge clk) begin
    #3;
    if (settled && !done) begin
      check(rdata == model_read(addr), "R8 model read", rdata, model_read(addr));
      check(irq == m_irq[0], "R6 model irq", irq, m_irq);
    end
  end

  always @(posedge clk) begin
    #3;
    if (addr == 2'd0 && rdata[3]) busy_cycles++;
  end

  // Input generators (inactive when half-period is 0).
  always @(negedge clk) begin
    if (am_half != 0) begin
      if (am_ctr >= am_half - 1) begin am_in <= ~am_in; am_ctr <= 0; end
      else am_ctr <= am_ctr + 1;
    end
    if (fm_half != 0) begin
      if (fm_ctr >= fm_half - 1) begin fm_in <= ~fm_in; fm_ctr <= 0; end
      else fm_ctr <= fm_ctr + 1;
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    #3 v = rdata;
    @(negedge clk);
    addr = 2'd0;
  endtask

  task automatic wait_gate_end();
    @(posedge clk); #4;
    while (rdata[3]) begin @(posedge clk); #4; end
    @(negedge clk);
  endtask

  task automatic read_count(output int c);
    logic [7:0] lo, hi;
    rd(2'd1, lo);
    rd(2'd2, hi);
    c = {hi, lo};
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int c;
    checks = 0; failures = 0; settled = 0; done = 0;
    am_half = 0; fm_half = 0; am_ctr = 0; fm_ctr = 0;
    fm_in = 0; am_in = 0; wr_en = 0; addr = 0; wdata = 0;
    rst_n = 0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (5) @(negedge clk);
    settled = 1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == 8'h00, "R1 reset read", v, 0);
    end
    check(irq == 1'b0, "R1 reset irq", irq, 0);

    // R2/R3: AM source, 1 ms gate
    am_half = 5;
    busy_cycles = 0;
    wr(2'd0, 8'b0000_1001);
    wait_gate_end();
    check(busy_cycles == TPM, "R3 gate 1ms cycles", busy_cycles, TPM);
    check(irq == 1'b1, "R6 irq after close", irq, 1);
    read_count(c);
    check(c == m_cnt, "R2 AM count vs model", c, m_cnt);
    check(c >= 19 && c <= 21, "R2 AM count range", c, 20);

    // R5: count holds after close
    repeat (30) @(negedge clk);
    read_count(c);
    check(c == m_cnt && c >= 19 && c <= 21, "R5 count holds", c, m_cnt);

    // R6: write 0 to flag bit leaves it, write 1 clears it
    wr(2'd0, 8'b0000_0001);
    check(irq == 1'b1, "R6 write 0 keeps flag", irq, 1);
    wr(2'd0, 8'b0001_0001);
    check(irq == 1'b0, "R6 w1c clears flag", irq, 0);

    // R2/R9: FM source, 4 ms gate, with an ignored write mid-gate
    fm_half = 3;
    busy_cycles = 0;
    wr(2'd0, 8'b0000_1010);
    repeat (100) @(negedge clk);
    wr(2'd0, 8'b0000_1101);
    rd(2'd0, v);
    check(v[0] == 1'b0 && v[2:1] == 2'b01, "R9 fields unchanged", v, 8'h0A);
    wait_gate_end();
    check(busy_cycles == 4 * TPM, "R9 gate length kept", busy_cycles, 4 * TPM);
    read_count(c);
    check(c == m_cnt, "R2 FM count vs model", c, m_cnt);
    check(c >= 64 && c <= 70, "R2 FM divided range", c, 67);
    fm_half = 0;
    wr(2'd0, 8'b0001_0001);

    // R3: 8 ms gate, AM
    am_half = 7;
    busy_cycles = 0;
    wr(2'd0, 8'b0000_1101);
    wait_gate_end();
    check(busy_cycles == 8 * TPM, "R3 gate 8ms cycles", busy_cycles, 8 * TPM);
    read_count(c);
    check(c == m_cnt, "R2 AM 8ms count vs model", c, m_cnt);

    // R3/R7: reserved code with fastest input -> saturation
    am_half = 1;
    busy_cycles = 0;
    wr(2'd0, 8'b0001_1111);
    wait_gate_end();
    check(busy_cycles == 8 * TPM, "R3 reserved code cycles", busy_cycles, 8 * TPM);
    read_count(c);
    check(c == CMAX, "R7 saturated count", c, CMAX);
    rd(2'd0, v);
    check(v[5] == 1'b1, "R7 overflow bit", v[5], 1);
    rd(2'd2, v);
    check(v == 8'h01, "R8 high byte upper bits zero", v, 1);

    // R4/R10: restart clears, single long pulse counts once with 2-edge latency
    am_half = 0;
    @(negedge clk) am_in = 0;
    repeat (4) @(negedge clk);
    wr(2'd0, 8'b0001_1001);
    rd(2'd0, v);
    check(v[3] == 1'b1 && v[5] == 1'b0, "R4 busy set ovf cleared", v, 8'h09);
    read_count(c);
    check(c == 0, "R4 count cleared", c, 0);
    @(negedge clk);
    addr = 2'd1;
    am_in = 1;
    @(posedge clk); #3;
    check(rdata == 8'd0, "R10 no count after edge k", rdata, 0);
    @(posedge clk); #3;
    check(rdata == 8'd0, "R10 no count after edge k+1", rdata, 0);
    @(posedge clk); #3;
    check(rdata == 8'd1, "R10 count after edge k+2", rdata, 1);
    repeat (40) @(negedge clk);
    addr = 2'd0;
    read_count(c);
    check(c == 1, "R10 level counted once", c, 1);
    wait_gate_end();
    rd(2'd3, v);
    check(v == 8'h00, "R8 address 3 reads zero", v, 0);

    repeat (5) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule